// File: doc/BRIEF.md
# Transmit Holding and Idle Status Tracker

This block sits between a host and a serial transmitter. Bytes the host writes are held in a staging store, which is either a single holding register or a first-in-first-out queue. From there they are handed to a shift register, one at a time. The serial bit timing stays outside the block. The block only needs a pulse telling it that the shift register has finished sending its byte.

Two status flags come out of the block:
- `hold_empty` reports that nothing is waiting in the staging store.
- `tx_idle` reports that nothing is waiting and nothing is being shifted.

The block hands bytes over by itself. It raises `sr_load` and updates `sr_byte`, and the serializer takes `sr_byte` at the edge that ends the `sr_load` cycle.

Top module: `tx_hold_status`

## Requirements
- R1: After reset, `hold_empty` = 1, `tx_idle` = 1 and `sr_load` = 0.
- R2: With `fifo_mode` = 0, the staging store holds one byte. A write while that byte is still waiting is ignored.
- R3: `hold_empty` goes to 0 right after the clock edge at which a host write (`wr_en` = 1) is accepted.
- R4: While the shifter is free and the store is not empty, `sr_load` = 1. At the next edge the oldest byte appears on `sr_byte` and leaves the store. In single-register mode `hold_empty` is then 1 again.
- R5: With `fifo_mode` = 1, `hold_empty` is 1 exactly when the queue is empty. Bytes reach `sr_byte` in the order they were written.
- R6: The queue holds `DEPTH` bytes (default 64). A write while it is full is ignored.
- R7: `tx_idle` = 1 only when the store is empty and the shifter is not busy. It is 0 whenever either stage holds a byte.
- R8: A `shift_done` pulse frees a busy shifter at its edge. A pulse while the shifter is free has no effect.
- R9: No load occurs while the shifter is busy. The next load is offered in the cycle after `shift_done` frees the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = queue of DEPTH bytes, 0 = single holding register |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | W | Host byte |
| shift_done | input | 1 | Shifter has finished its current byte |
| sr_load | output | 1 | Byte handed to shifter at this edge |
| sr_byte | output | W | Byte held by the shift register |
| hold_empty | output | 1 | Staging store empty |
| tx_idle | output | 1 | Staging store and shifter both empty |

## Verification
The hardest state to reach from the ports is a completely full queue that also receives one more write, while the shifter already holds a byte. The stimulus loads one byte into the shifter and keeps it busy by withholding `shift_done`. It then writes `DEPTH` bytes plus one extra. Draining the queue pulse by pulse afterwards shows that the extra byte never appears on `sr_byte`, and that the order is preserved across the pointer wrap.

// File: rtl/tx_hold_status.sv
module tx_hold_status #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         shift_done,
  output logic         sr_load,
  output logic [W-1:0] sr_byte,
  output logic         hold_empty,
  output logic         tx_idle
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLN = CW'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [CW-1:0] cap;
  logic          push;

  assign cap        = fifo_mode ? FULLN : CW'(1);
  assign push       = wr_en && (cnt < cap);
  assign sr_load    = !busy && (cnt != '0);
  assign hold_empty = (cnt == '0);
  assign tx_idle    = hold_empty && !busy;

  always_ff @(posedge clk) if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      sr_byte <= '0;
    end else begin
      if (push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (sr_load) begin
        rp      <= (rp == LASTP) ? '0 : rp + 1'b1;
        sr_byte <= mem[rp];
      end
      cnt <= cnt + CW'(push) - CW'(sr_load);
      if (sr_load)                busy <= 1'b1;
      else if (busy && shift_done) busy <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLN); // R6
  AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (hold_empty && !busy)); // R7
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !sr_load) |=> !hold_empty); // R3
  AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt >= cap && !sr_load) |=> $stable(cnt)); // R2
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> (busy && !sr_load)); // R9
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && shift_done && !sr_load) |=> !busy); // R8
endmodule

// File: tb/sim_tx_hold_status.sv
module sim_tx_hold_status;
  logic clk = 0, rst_n = 0, fifo_mode = 0, wr_en = 0, shift_done = 0;
  logic [7:0] wr_data = 0;
  logic sr_load, hold_empty, tx_idle;
  logic [7:0] sr_byte;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tx_hold_status #(.W(8), .DEPTH(64)) u0 (.*);

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic done_pulse();
    shift_done = 1; cyc(); shift_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 hold_empty", hold_empty, 1);
    chk("R1 tx_idle", tx_idle, 1);
    chk("R1 sr_load", sr_load, 0);
  endtask

  task automatic t_single();
    fifo_mode = 0;
    wr(8'hA5);
    chk("R3 hold_empty after write", hold_empty, 0);
    chk("R7 idle with byte held", tx_idle, 0);
    chk("R4 load offered", sr_load, 1);
    cyc();
    chk("R4 byte in shifter", sr_byte, 8'hA5);
    chk("R4 hold_empty after load", hold_empty, 1);
    chk("R7 idle while shifting", tx_idle, 0);
    wr(8'h3C);
    chk("R9 no load while busy", sr_load, 0);
    wr(8'hFF);
    done_pulse();
    chk("R9 load after free", sr_load, 1);
    cyc();
    chk("R2 held byte kept", sr_byte, 8'h3C);
    chk("R2 extra write ignored", hold_empty, 1);
    done_pulse();
    chk("R7 idle after done", tx_idle, 1);
    chk("R2 nothing left", sr_load, 0);
    done_pulse();
    chk("R8 stray done idle", tx_idle, 1);
    chk("R8 stray done no load", sr_load, 0);
  endtask

  task automatic t_fifo_order();
    fifo_mode = 1;
    for (int i = 0; i < 5; i++) wr(8'(8'h10 + i));
    chk("R4 first byte loaded", sr_byte, 8'h10);
    chk("R5 hold_empty with data", hold_empty, 0);
    for (int i = 1; i < 5; i++) begin
      done_pulse(); cyc();
      chk("R5 order", sr_byte, 8'h10 + i);
    end
    chk("R5 hold_empty drained", hold_empty, 1);
    chk("R7 not idle while shifting", tx_idle, 0);
    done_pulse();
    chk("R7 idle after last", tx_idle, 1);
  endtask

  task automatic t_fifo_full();
    fifo_mode = 1;
    wr(8'h80); cyc();
    chk("R6 shifter holds first", sr_byte, 8'h80);
    for (int i = 0; i < 64; i++) wr(8'(i));
    wr(8'hEE);
    chk("R6 full not empty", hold_empty, 0);
    for (int i = 0; i < 64; i++) begin
      done_pulse(); cyc();
      chk("R6 drain order", sr_byte, i);
    end
    chk("R6 overflow byte dropped", hold_empty, 1);
    done_pulse();
    chk("R6 idle at end", tx_idle, 1);
    chk("R6 no extra load", sr_load, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; cyc();
    t_reset();
    t_single();
    t_fifo_order();
    t_fifo_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule